// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Selector

This block provides the four threshold offsets used by the flag logic of a pair of FIFOs that carry data in opposite directions. The first FIFO runs from port A to port B and the second from port B to port A. For each FIFO there is an almost-empty offset for the reading side and an almost-full offset for the writing side. Each pair belongs to one FIFO and is set when that FIFO leaves its own reset.

When a FIFO reset is released, a two-bit select input is sampled. Three select codes load a fixed depth into both registers of that FIFO's pair. The preset is limited to the FIFO depth minus one. The fourth code arms a programming mode. Once both FIFOs have been released with that code, the next four writes on port A load all four offsets from the low bits of the data word. No data goes to the FIFOs during that time. A busy output is high while programming is pending, so the surrounding logic can hold both input-ready flags low.

All outputs are registered and run on a single clock. The block has its own synchronous active-high reset, and the two FIFO resets are active-high level inputs that are sampled on that clock.

Top module: `flag_ofs_prog`

## Requirements
- R1: After the block reset, all four offset outputs are 0 and `prog_busy` is 0.
- R2: The select is sampled only in the cycle where a FIFO clear input is seen low after being high. Select values presented at any other time do not change any output.
- R3: The select encoding is 2'b11 for 64, 2'b10 for 16, 2'b01 for 8 and 2'b00 for programming mode. A preset appears on the outputs one cycle after the release cycle.
- R4: Releasing `clr_ab` loads `ae_b_off` and `af_a_off` only. Releasing `clr_ba` loads `ae_a_off` and `af_b_off` only. Both registers of the pair receive the same preset.
- R5: A release with select 2'b00 arms that FIFO. `prog_busy` rises one cycle after the release and stays high while either FIFO is armed.
- R6: Port-A writes (`wr_en` high) are taken as offsets only when both FIFOs are armed. The writes load `ae_b_off`, `af_a_off`, `ae_a_off` and `af_b_off` in that order, from bits [OFF_W-1:0] of `wr_data`, each one cycle after its write.
- R7: `prog_busy` falls one cycle after the fourth offset write.
- R8: A write taken while programming is not active changes no offset.
- R9: A preset is limited to DEPTH-1. With DEPTH=16, the codes 2'b11 and 2'b10 give 15 and 2'b01 gives 8.
- R10: Any FIFO release during pending programming restarts the write order at `ae_b_off`. A release with a preset code clears that FIFO's arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high block reset |
| clr_ab | input | 1 | Active-high reset of the A-to-B FIFO; its release is sampled |
| clr_ba | input | 1 | Active-high reset of the B-to-A FIFO; its release is sampled |
| sel | input | 2 | Offset select code sampled on a release |
| wr_en | input | 1 | Port-A write strobe |
| wr_data | input | DATA_W | Port-A write data |
| ae_b_off | output | OFF_W | Almost-empty offset, port-B side (A-to-B FIFO) |
| af_a_off | output | OFF_W | Almost-full offset, port-A side (A-to-B FIFO) |
| ae_a_off | output | OFF_W | Almost-empty offset, port-A side (B-to-A FIFO) |
| af_b_off | output | OFF_W | Almost-full offset, port-B side (B-to-A FIFO) |
| prog_busy | output | 1 | Offset programming pending |

## Verification
Every result is due exactly one clock after the edge that samples its cause. For presets and arming, that edge is the first edge with the clear low after it was high. For offset writes and the busy drop, it is the edge that takes the write. The bench drives all inputs on falling edges and checks on the next falling edge after the sampling rising edge, so each check lands half a period after the register update. A second instance with a small depth exposes the preset limit, and re-release tests confirm that the write order restarts.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

    typedef enum logic [1:0] {
        SEL_PROG = 2'b00,
        SEL_D8   = 2'b01,
        SEL_D16  = 2'b10,
        SEL_D64  = 2'b11
    } ofs_sel_e;

    localparam int unsigned N_FIFO   = 2;
    localparam int unsigned N_OFS    = 4;
    localparam int unsigned PER_FIFO = N_OFS / N_FIFO;
    localparam int unsigned IDX_W    = $clog2(N_OFS);

    typedef struct packed {
        logic rel;
        logic preset_ld;
        logic arm_req;
    } rel_evt_t;

    function automatic logic [31:0] preset_of(ofs_sel_e s);
        case (s)
            SEL_D64: return 32'd64;
            SEL_D16: return 32'd16;
            SEL_D8:  return 32'd8;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] clamp_to(logic [31:0] v, logic [31:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/ofs_rel_decode.sv
module ofs_rel_decode
    import flag_ofs_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned OFF_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  ofs_sel_e         sel,
    output rel_evt_t         evt,
    output logic [OFF_W-1:0] preset_val
);

    logic        clr_q;
    logic [31:0] lim_v;

    always_ff @(posedge clk) begin
        if (rst) clr_q <= 1'b0;
        else     clr_q <= clr;
    end

    always_comb begin
        evt.rel       = clr_q & ~clr;
        evt.preset_ld = evt.rel & (sel != SEL_PROG);
        evt.arm_req   = evt.rel & (sel == SEL_PROG);
        lim_v         = clamp_to(preset_of(sel), 32'(DEPTH - 1));
        preset_val    = lim_v[OFF_W-1:0];
    end

endmodule

// File: rtl/ofs_prog_seq.sv
module ofs_prog_seq
    import flag_ofs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_FIFO-1:0] rel,
    input  logic [N_FIFO-1:0] arm_req,
    input  logic              wr_en,
    output logic              wr_ld,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              busy
);

    logic [N_FIFO-1:0] arm_q;
    logic [IDX_W-1:0]  idx_q;
    logic              any_rel;

    always_comb begin
        any_rel = |rel;
        wr_ld   = wr_en & (&arm_q) & ~any_rel;
        wr_idx  = idx_q;
        busy    = |arm_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= '0;
            idx_q <= '0;
        end else if (any_rel) begin
            for (int i = 0; i < N_FIFO; i++)
                if (rel[i]) arm_q[i] <= arm_req[i];
            idx_q <= '0;
        end else if (wr_ld) begin
            if (idx_q == IDX_W'(N_OFS - 1)) begin
                arm_q <= '0;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R5
    arm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(|arm_req));

    // R7
    done_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ld && idx_q == IDX_W'(N_OFS - 1)) |=> !busy);

    // R6
    idx_chk: assert property (@(posedge clk) disable iff (rst)
        !(&arm_q) |-> (idx_q == '0));

endmodule

// File: rtl/flag_ofs_prog.sv
module flag_ofs_prog
    import flag_ofs_pkg::*;
#(
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned DATA_W = 36,
    localparam int unsigned OFF_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_ab,
    input  logic              clr_ba,
    input  logic [1:0]        sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [OFF_W-1:0]  ae_b_off,
    output logic [OFF_W-1:0]  af_a_off,
    output logic [OFF_W-1:0]  ae_a_off,
    output logic [OFF_W-1:0]  af_b_off,
    output logic              prog_busy
);

    logic [N_FIFO-1:0] clr_v;
    rel_evt_t          evt [N_FIFO];
    logic [OFF_W-1:0]  pval [N_FIFO];
    logic [N_FIFO-1:0] rel_v, arm_v;
    logic              any_ld;
    logic              wr_ld;
    logic [IDX_W-1:0]  wr_idx;
    logic [OFF_W-1:0]  off_q [N_OFS];

    assign clr_v = {clr_ba, clr_ab};

    for (genvar g = 0; g < N_FIFO; g++) begin : g_dec
        ofs_rel_decode #(.DEPTH(DEPTH)) u_dec (
            .clk        (clk),
            .rst        (rst),
            .clr        (clr_v[g]),
            .sel        (ofs_sel_e'(sel)),
            .evt        (evt[g]),
            .preset_val (pval[g])
        );
    end

    always_comb begin
        any_ld = 1'b0;
        for (int i = 0; i < N_FIFO; i++) begin
            rel_v[i] = evt[i].rel;
            arm_v[i] = evt[i].arm_req;
            any_ld   = any_ld | evt[i].preset_ld;
        end
    end

    ofs_prog_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .rel     (rel_v),
        .arm_req (arm_v),
        .wr_en   (wr_en),
        .wr_ld   (wr_ld),
        .wr_idx  (wr_idx),
        .busy    (prog_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < N_OFS; j++) off_q[j] <= '0;
        end else begin
            for (int j = 0; j < N_OFS; j++) begin
                if (evt[j / PER_FIFO].preset_ld)
                    off_q[j] <= pval[j / PER_FIFO];
                else if (wr_ld && wr_idx == IDX_W'(j))
                    off_q[j] <= wr_data[OFF_W-1:0];
            end
        end
    end

    assign ae_b_off = off_q[0];
    assign af_a_off = off_q[1];
    assign ae_a_off = off_q[2];
    assign af_b_off = off_q[3];

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!any_ld && !wr_ld) |=> ($stable(ae_b_off) && $stable(af_a_off)
                                 && $stable(ae_a_off) && $stable(af_b_off)));

    // R4
    pair_ab_chk: assert property (@(posedge clk) disable iff (rst)
        evt[0].preset_ld |=> (ae_b_off == af_a_off));

    // R4
    pair_ba_chk: assert property (@(posedge clk) disable iff (rst)
        evt[1].preset_ld |=> (ae_a_off == af_b_off));

endmodule

// File: tb/sim_flag_ofs_prog.sv
`timescale 1ns/1ps
module sim_flag_ofs_prog;

    localparam int unsigned DATA_W = 36;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        clr = 2'b00;
    logic [1:0]        sel = 2'b00;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [8:0]        a0, a1, a2, a3;
    logic [3:0]        b0, b1, b2, b3;
    logic              busy0, busy1;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp0 [4];
    int exp1 [4];

    always #4 clk = ~clk;

    flag_ofs_prog #(.DEPTH(512), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .clr_ab(clr[0]), .clr_ba(clr[1]), .sel(sel),
        .wr_en(wr_en), .wr_data(wr_data),
        .ae_b_off(a0), .af_a_off(a1), .ae_a_off(a2), .af_b_off(a3),
        .prog_busy(busy0));

    flag_ofs_prog #(.DEPTH(16), .DATA_W(DATA_W)) u1 (
        .clk(clk), .rst(rst), .clr_ab(clr[0]), .clr_ba(clr[1]), .sel(sel),
        .wr_en(wr_en), .wr_data(wr_data),
        .ae_b_off(b0), .af_a_off(b1), .ae_a_off(b2), .af_b_off(b3),
        .prog_busy(busy1));

    // fifo [9], select [8:7], preset [6:0]
    localparam logic [9:0] VEC [6] = '{
        {1'b0, 2'b11, 7'd64}, {1'b1, 2'b10, 7'd16}, {1'b0, 2'b01, 7'd8},
        {1'b1, 2'b11, 7'd64}, {1'b0, 2'b10, 7'd16}, {1'b1, 2'b01, 7'd8}
    };

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic chk_all0(string req);
        chk(req, a0, exp0[0]); chk(req, a1, exp0[1]);
        chk(req, a2, exp0[2]); chk(req, a3, exp0[3]);
    endtask

    task automatic chk_all1(string req);
        chk(req, b0, exp1[0]); chk(req, b1, exp1[1]);
        chk(req, b2, exp1[2]); chk(req, b3, exp1[3]);
    endtask

    task automatic release_fifo(int f, logic [1:0] s);
        @(negedge clk); clr[f] = 1'b1; sel = ~s;
        @(negedge clk);
        @(negedge clk); clr[f] = 1'b0; sel = s;
        @(negedge clk); sel = ~s;
    endtask

    task automatic write_word(logic [DATA_W-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin exp0[i] = 0; exp1[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_all0("R1"); chk_all1("R1");
        chk("R1 busy", busy0, 0);

        // R3 R4 R9 preset table
        for (int v = 0; v < 6; v++) begin
            int f, val;
            f   = VEC[v][9];
            val = VEC[v][6:0];
            release_fifo(f, VEC[v][8:7]);
            exp0[2*f] = val; exp0[2*f+1] = val;
            exp1[2*f] = (val > 15) ? 15 : val; exp1[2*f+1] = exp1[2*f];
            chk_all0("R3 R4"); chk_all1("R9");
            chk("R3 busy", busy0, 0);
        end

        // R2 select ignored while clear is held
        @(negedge clk); clr[0] = 1'b1; sel = 2'b00;
        repeat (3) @(negedge clk);
        sel = 2'b11;
        @(negedge clk);
        chk_all0("R2"); chk("R2 busy", busy0, 0);
        clr[0] = 1'b0; sel = 2'b10;
        @(negedge clk); sel = 2'b00;
        exp0[0] = 16; exp0[1] = 16;
        chk_all0("R2 release");

        // R8 writes outside programming
        write_word(36'h0_0000_0123);
        chk_all0("R8");

        // R5 R6 arming one FIFO only
        release_fifo(0, 2'b00);
        chk("R5 busy", busy0, 1);
        chk_all0("R5");
        write_word(36'h0_0000_0055);
        chk_all0("R6 single arm");
        release_fifo(1, 2'b00);
        chk("R5 busy both", busy0, 1);

        // R6 four ordered writes, low bits only
        write_word(36'hA_BCDE_0003); exp0[0] = 3;   chk_all0("R6 w1");
        write_word(36'h5_5550_0064); exp0[1] = 100; chk_all0("R6 w2");
        write_word(36'hF_FFFF_FEC8); exp0[2] = 200; chk_all0("R6 w3");
        chk("R6 busy mid", busy0, 1);
        write_word(36'h1_0000_01FF); exp0[3] = 511; chk_all0("R6 w4");
        // R7
        chk("R7 busy", busy0, 0);
        write_word(36'h0_0000_0001);
        chk_all0("R8 after done");

        // R10 re-release restarts order
        release_fifo(0, 2'b00);
        release_fifo(1, 2'b00);
        write_word(36'h7); exp0[0] = 7; chk_all0("R10 first");
        release_fifo(1, 2'b00);
        write_word(36'd11); exp0[0] = 11; chk_all0("R10 restart");
        write_word(36'd12); exp0[1] = 12;
        write_word(36'd13); exp0[2] = 13;
        write_word(36'd14); exp0[3] = 14;
        chk_all0("R10 order"); chk("R10 busy", busy0, 0);

        // R10 preset release clears arm
        release_fifo(0, 2'b00);
        release_fifo(1, 2'b11);
        exp0[2] = 64; exp0[3] = 64;
        chk("R10 busy held", busy0, 1);
        chk_all0("R10 preset");
        release_fifo(0, 2'b10);
        exp0[0] = 16; exp0[1] = 16;
        chk("R10 busy clear", busy0, 0);
        chk_all0("R10 preset2");

        // R1 reset mid-programming
        release_fifo(0, 2'b00);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) exp0[i] = 0;
        chk_all0("R1 again"); chk("R1 busy again", busy0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule